// File: doc/BRIEF.md
# Serial Configuration Memory Sequencer

This block is the read side of a serial bitstream store. It holds a configuration image in a small on-chip array and presents it one bit per clock on a single data line. A downstream loader takes each bit on the rising clock edge. An internal byte address and a three-bit bit index step the read position. The position advances only on clock edges where the chip is selected and its output is enabled.

One pin does two jobs. When the combined reset/output-enable input is in its reset state, it clears the read position at once and takes the data line off the bus. When it is in its enable state, the data line may drive. A chain of these stores is built by wiring each cascade-enable output to the next store's chip enable. Once this store has shifted out its full capacity, it goes quiet and its cascade output selects the next store in the chain.

`CAPACITY_BITS` sets the capacity. The default is 1,048,576 bits, and 4,194,304 bits is also supported; the value must be a power-of-two number of bytes. The physical array (`STORE_BYTES` bytes) is smaller and repeats across the address space. The reset polarity comes from `RST_ACTIVE_HIGH`, which defaults to an active-high reset.

Top module: `bitstream_reader`

## Requirements
- R1: While `rstOe` is high (default polarity), the read position goes to bit 0 at once and stays there, `dataOe` is low and `ceoN` is high.
- R2: After reset, bits leave MSB-first within each byte: bit index 7 of byte 0 first, then down to index 0, after which the byte address steps by one.
- R3: The read position holds on any clock edge where `ceN` is high, `rstOe` is high, or the capacity is used up. Once the block is selected again, it resumes with the next unread bit.
- R4: `dataOe` is high exactly when `ceN` is low, `rstOe` is low and the capacity is not yet used up. While `dataOe` is low, `dataOut` is 0.
- R5: The byte at address a holds ((a mod STORE_BYTES) * 29 + 113) mod 256.
- R6: On the clock edge that shifts out bit number CAPACITY_BITS-1, `ceoN` falls. It then stays low with `dataOe` low and the position frozen until the next reset.
- R7: `ceoN` stays high while fewer than CAPACITY_BITS bits have been shifted since the last reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the read position advances on its rising edge |
| ceN | input | 1 | Chip enable, active low |
| rstOe | input | 1 | Combined reset / output enable; reset level set by RST_ACTIVE_HIGH |
| dataOut | output | 1 | Serial data bit, 0 when released |
| dataOe | output | 1 | High while `dataOut` drives the line |
| ceoN | output | 1 | Cascade enable to the next store, active low |

## Verification
The bench plays an uninterrupted stream from reset to the end of capacity. That run separates bit ordering within a byte and byte stepping from the array contents. It also shows that the cascade hand-off falls on exactly the last bit. Pauses on chip enable are placed mid-byte, which separates true holding from silent skipping. Resets are applied mid-stream and after exhaustion, which shows that the restart always begins at bit 0 and clears the cascade. Random mixes of selection and reset then test the output-enable gating against all reachable combinations of position and state.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;      // advance the bit index this edge
    logic nextByte;  // bit index wraps, advance byte address
  } bsrStrobe_t;

  // Contents of the stored image, one byte per array slot
  function automatic logic [7:0] imageByte(input int unsigned idx);
    return 8'((idx * 29 + 113) % 256);
  endfunction

endpackage

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int unsigned CAPACITY_BITS = 1048576,
  parameter int unsigned STORE_BYTES   = 64,
  localparam int unsigned NUM_BYTES    = CAPACITY_BITS / 8,
  localparam int unsigned ADDR_W       = $clog2(NUM_BYTES),
  localparam int unsigned IDX_W        = $clog2(STORE_BYTES)
) (
  input  logic              clk,
  input  logic              resetAct,
  input  bsrStrobe_t        strobe,
  output logic              curBit,
  output logic              bitEnd,
  output logic              atLastBit,
  output logic [ADDR_W-1:0] byteAddr,
  output logic [2:0]        bitIdx
);

  logic [7:0] image [STORE_BYTES];
  logic [7:0] selByte;

  // Fixed image contents, one slot per generate iteration
  for (genvar g = 0; g < STORE_BYTES; g++) begin : g_image
    assign image[g] = imageByte(g);
  end

  always_ff @(posedge clk or posedge resetAct) begin
    if (resetAct) begin
      byteAddr <= '0;
      bitIdx   <= '0;
    end else if (strobe.step) begin
      bitIdx <= bitIdx + 3'd1;
      if (strobe.nextByte) byteAddr <= byteAddr + ADDR_W'(1);
    end
  end

  always_comb begin
    selByte   = image[byteAddr[IDX_W-1:0]];
    curBit    = selByte[3'd7 - bitIdx];
    bitEnd    = (bitIdx == 3'd7);
    atLastBit = bitEnd && (byteAddr == ADDR_W'(NUM_BYTES - 1));
  end

endmodule

// File: rtl/bsr_control.sv
module bsr_control
  import bsr_pkg::*;
(
  input  logic       clk,
  input  logic       resetAct,
  input  logic       ceN,
  input  logic       bitEnd,
  input  logic       atLastBit,
  output bsrStrobe_t strobe,
  output logic       driveEn,
  output logic       exhausted
);

  always_comb begin
    driveEn         = !ceN && !resetAct && !exhausted;
    strobe.step     = driveEn;
    strobe.nextByte = driveEn && bitEnd;
  end

  always_ff @(posedge clk or posedge resetAct) begin
    if (resetAct)                 exhausted <= 1'b0;
    else if (driveEn && atLastBit) exhausted <= 1'b1;
  end

endmodule

// File: rtl/bitstream_reader.sv
module bitstream_reader
  import bsr_pkg::*;
#(
  parameter int unsigned CAPACITY_BITS   = 1048576,
  parameter int unsigned STORE_BYTES     = 64,
  parameter bit          RST_ACTIVE_HIGH = 1'b1,
  localparam int unsigned ADDR_W         = $clog2(CAPACITY_BITS / 8)
) (
  input  logic clk,
  input  logic ceN,
  input  logic rstOe,
  output logic dataOut,
  output logic dataOe,
  output logic ceoN
);

  logic              resetAct;
  bsrStrobe_t        strobe;
  logic              curBit, bitEnd, atLastBit, driveEn, exhausted;
  logic [ADDR_W-1:0] byteAddr;
  logic [2:0]        bitIdx;

  assign resetAct = (rstOe == RST_ACTIVE_HIGH);

  bsr_control ctrl_i (
    .clk       (clk),
    .resetAct  (resetAct),
    .ceN       (ceN),
    .bitEnd    (bitEnd),
    .atLastBit (atLastBit),
    .strobe    (strobe),
    .driveEn   (driveEn),
    .exhausted (exhausted)
  );

  bsr_datapath #(
    .CAPACITY_BITS (CAPACITY_BITS),
    .STORE_BYTES   (STORE_BYTES)
  ) dp_i (
    .clk       (clk),
    .resetAct  (resetAct),
    .strobe    (strobe),
    .curBit    (curBit),
    .bitEnd    (bitEnd),
    .atLastBit (atLastBit),
    .byteAddr  (byteAddr),
    .bitIdx    (bitIdx)
  );

  assign dataOe  = driveEn;
  assign dataOut = driveEn & curBit;
  assign ceoN    = ~exhausted;

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter bit          RST_ACTIVE_HIGH = 1'b1,
  parameter int unsigned POS_W           = 8
) (
  input logic             clk,
  input logic             ceN,
  input logic             rstOe,
  input logic             dataOut,
  input logic             dataOe,
  input logic             ceoN,
  input logic [POS_W-1:0] posCnt
);

  logic rstAct;
  assign rstAct = (rstOe == RST_ACTIVE_HIGH);

  // R4: released line carries no data
  p_release_r4: assert property (@(posedge clk) disable iff (rstAct)
    !dataOe |-> !dataOut);

  // R4: deselected chip never drives
  p_oe_gate_r4: assert property (@(posedge clk) disable iff (rstAct)
    ceN |-> !dataOe);

  // R2: one bit of progress per selected edge
  p_step_r2: assert property (@(posedge clk) disable iff (rstAct)
    (!ceN && ceoN) |=> posCnt == POS_W'($past(posCnt) + 1'b1));

  // R3: position frozen when deselected or exhausted
  p_hold_r3: assert property (@(posedge clk) disable iff (rstAct)
    (ceN || !ceoN) |=> $stable(posCnt));

  // R6: cascade stays asserted until reset, line quiet
  p_cascade_sticky_r6: assert property (@(posedge clk) disable iff (rstAct)
    !ceoN |=> !ceoN);
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (rstAct)
    !ceoN |-> !dataOe);

  // R7: cascade only asserts after a bit was shifted
  p_ceo_entry_r7: assert property (@(posedge clk) disable iff (rstAct)
    $fell(ceoN) |-> $past(dataOe));

endmodule

bind bitstream_reader bsr_checker #(
  .RST_ACTIVE_HIGH (RST_ACTIVE_HIGH),
  .POS_W           (ADDR_W + 3)
) chk_i (
  .clk     (clk),
  .ceN     (ceN),
  .rstOe   (rstOe),
  .dataOut (dataOut),
  .dataOe  (dataOe),
  .ceoN    (ceoN),
  .posCnt  ({byteAddr, bitIdx})
);

// File: tb/bitstream_reader_tb_top.sv
module bitstream_reader_tb_top;

  localparam int CAP   = 256;
  localparam int STORE = 16;

  logic clk = 1'b0;
  logic ceN = 1'b1;
  logic rstOe = 1'b1;
  logic dataOut, dataOe, ceoN;

  int errors = 0;
  int checks = 0;
  int mPos = 0;
  bit mDone = 1'b0;

  always #5 clk = ~clk;

  bitstream_reader #(
    .CAPACITY_BITS   (CAP),
    .STORE_BYTES     (STORE),
    .RST_ACTIVE_HIGH (1'b1)
  ) dut_i (
    .clk     (clk),
    .ceN     (ceN),
    .rstOe   (rstOe),
    .dataOut (dataOut),
    .dataOe  (dataOe),
    .ceoN    (ceoN)
  );

  // R5 image contents, R2 MSB-first ordering
  function automatic bit expBit(input int pos);
    int b;
    logic [7:0] v;
    b = (pos / 8) % STORE;
    v = 8'((b * 29 + 113) % 256);
    return v[7 - (pos % 8)];
  endfunction

  task automatic checkOne(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", tag, mPos, act, exp);
    end
  endtask

  // Drive one cycle: inputs at negedge, outputs checked just after, model stepped at posedge
  task automatic cycle(input string ctx, input bit ce, input bit rst);
    logic eOe, eData;
    ceN   = ce;
    rstOe = rst;
    if (rst) begin
      mPos  = 0;
      mDone = 1'b0;
    end
    #1;
    eOe   = !ce && !rst && !mDone;
    eData = eOe ? expBit(mPos) : 1'b0;
    checkOne({ctx, " R4 dataOe"}, dataOe, eOe);
    checkOne({ctx, " R2 R5 dataOut"}, dataOut, eData);
    checkOne({ctx, " R6 R7 ceoN"}, ceoN, !mDone);
    @(posedge clk);
    if (eOe) begin
      mPos++;
      if (mPos == CAP) mDone = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    process::self().srandom(32'd1234);
    @(negedge clk);
    // R1: reset state held
    for (int i = 0; i < 3; i++) cycle("R1 reset", 1'b0, 1'b1);
    // R2: first bits in order
    for (int i = 0; i < 20; i++) cycle("R2 stream", 1'b0, 1'b0);
    // R3: pause mid-byte, then resume with the next bit
    for (int i = 0; i < 5; i++) cycle("R3 hold", 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) cycle("R3 resume", 1'b0, 1'b0);
    // R1: reset mid-stream restarts at bit 0
    cycle("R1 midreset", 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) cycle("R1 restart", 1'b0, 1'b0);
    // R6: run to the end of capacity and beyond
    while (!mDone) cycle("R6 run", 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cycle("R6 after", 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) cycle("R6 deselect", 1'b1, 1'b0);
    // R1: reset after exhaustion clears cascade
    cycle("R1 clear", 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) cycle("R7 again", 1'b0, 1'b0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      bit rce, rrst;
      rce  = ($urandom % 100) < 20;
      rrst = ($urandom % 100) < 2;
      cycle("R3 R4 random", rce, rrst);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule